// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Engine

This block multiplies one square tile of signed 32-bit integers by a second one and writes the square result tile to an output scratchpad. The three scratchpads sit outside the block; the engine reaches them through two operand read ports, one result read port and one result write port. Each port moves one line of `SUB` words per cycle. The second operand is held transposed, so both operand tiles are fetched row by row. A single `start` pulse launches a run. `done` pulses once when the whole result tile has been written.

The result tile is walked in `SUB` x `SUB` output sub-blocks. For each sub-block the engine works through the shared dimension one `SUB`-wide slice at a time. It copies `SUB` lines of each operand into one of two flat register banks. A grid of `SUB` x `SUB` multiply-accumulate lanes then consumes one column of the staged bank per cycle. While the lanes work from one bank, the fetch side fills the other.

After the last slice, the sub-block is written back row by row. The `accumulate` flag is captured at `start`. When it is set, each written word is the freshly computed sum plus the word already held in the result scratchpad, so partial products of larger matrices can be summed one block pair per run. When it is clear, the old contents are replaced.

Top module: `tmm_tile_engine`

## Requirements
- R1: During reset, and afterwards until a run is started, `done`, `opa_rd_en`, `opb_rd_en`, `res_rd_en` and `res_wr_en` are all low.
- R2: With `accumulate` low at start, every result element C[i][j] is written as the sum over k of A[i][k]*B[k][j]. The layout rules are as follows. Line address r*NB+q (NB = TILE/SUB) holds row r, and lane w (bits w*DW upward) of that line holds column q*SUB+w. This applies to operand A and to the result. The operand B port holds the transposed tile, so lane w of line j*NB+q holds B[q*SUB+w][j]. Every scratchpad returns read data one cycle after its enable.
- R3: With `accumulate` high at start, every written word equals the word read from the same result location during the run, plus the new sum from R2.
- R4: Operands are two's complement 32-bit values; products and sums are kept modulo 2^32.
- R5: Each result line is written exactly once per run. Sub-blocks are written in row-major order of their block coordinates, and the rows within a sub-block are written in ascending order on consecutive write cycles.
- R6: `done` is high for exactly one cycle, the cycle after the final result write, and no write follows it within the run.
- R7: A `start` pulse given while a run is in progress is ignored: the result and the single `done` pulse are unchanged.
- R8: `accumulate` is sampled only in the cycle `start` is accepted; changing it later in the run has no effect on the result.
- R9: With operand banks double-buffered, `done` arrives no later than NB^3*(SUB+1) + NB^2*(SUB+1) + 2*SUB + 8 cycles after `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run when idle |
| accumulate | input | 1 | Add to the existing result tile (sampled at start) |
| done | output | 1 | One-cycle pulse after the last result write |
| opa_rd_en | output | 1 | Operand A read enable |
| opa_rd_addr | output | clog2(TILE*NB) | Operand A line address |
| opa_rd_data | input | SUB*DW | Operand A line, one cycle after enable |
| opb_rd_en | output | 1 | Transposed operand B read enable |
| opb_rd_addr | output | clog2(TILE*NB) | Transposed operand B line address |
| opb_rd_data | input | SUB*DW | Operand B line, one cycle after enable |
| res_rd_en | output | 1 | Result scratchpad read enable |
| res_rd_addr | output | clog2(TILE*NB) | Result read line address |
| res_rd_data | input | SUB*DW | Result line, one cycle after enable |
| res_wr_en | output | 1 | Result write enable |
| res_wr_addr | output | clog2(TILE*NB) | Result write line address |
| res_wr_data | output | SUB*DW | Result line to write |

## Verification
The bench builds the engine with an 8x8 tile and 4x4 sub-blocks. This gives two sub-blocks per dimension, eight operand slices and four write-back phases per run. That is enough to cross sub-block boundaries in both output directions, to use both staging banks several times over, and to reach the accumulate path across successive slices, all in a few dozen cycles per run. Its reference model predicts every result-line write in order and compares address and data on each clock. The patterns include identity, mixed signs, values near the 32-bit limits and pseudo-random data, with start and accumulate disturbed mid-run.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_MAC  = 2'd1,
        CS_WB   = 2'd2
    } cstate_e;

    // Index width for a count of n items, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Scratchpad line holding row 'row', column block 'blk'.
    function automatic int unsigned line_of(input int unsigned row,
                                            input int unsigned blk,
                                            input int unsigned nb);
        return row * nb + blk;
    endfunction

endpackage

// File: rtl/tmm_fetch.sv
module tmm_fetch import tmm_pkg::*; #(
    parameter int TILE = 64,
    parameter int SUB  = 16,
    parameter int DW   = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 go,
    input  logic                                 rd_sel,
    input  logic [idx_w(SUB)-1:0]                k_idx,
    input  logic                                 release_bank,
    output logic                                 opa_rd_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]    opa_rd_addr,
    input  logic [SUB*DW-1:0]                    opa_rd_data,
    output logic                                 opb_rd_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]    opb_rd_addr,
    input  logic [SUB*DW-1:0]                    opb_rd_data,
    output logic [1:0]                           bank_full,
    output logic [SUB*DW-1:0]                    a_col,
    output logic [SUB*DW-1:0]                    b_col
);

    localparam int NB = TILE / SUB;
    localparam int BW = idx_w(NB);
    localparam int RW = idx_w(SUB);
    localparam int AW = idx_w(TILE * NB);
    localparam logic [RW-1:0] R_LAST = RW'(SUB - 1);
    localparam logic [BW-1:0] B_LAST = BW'(NB - 1);

    typedef struct packed {
        logic          vld;
        logic          bank;
        logic [RW-1:0] row;
    } fill_t;

    logic          active;
    logic          wsel;
    logic          issue;
    logic [BW-1:0] f_bi, f_bj, f_kb;
    logic [RW-1:0] f_r;
    logic [1:0]    full;
    fill_t         pend;

    logic [DW-1:0] a_bank [2][SUB][SUB];
    logic [DW-1:0] b_bank [2][SUB][SUB];

    assign issue       = active && !full[wsel];
    assign opa_rd_en   = issue;
    assign opb_rd_en   = issue;
    assign opa_rd_addr = AW'(line_of(32'(f_bi) * SUB + 32'(f_r), 32'(f_kb), NB));
    assign opb_rd_addr = AW'(line_of(32'(f_bj) * SUB + 32'(f_r), 32'(f_kb), NB));
    assign bank_full   = full;

    // Walk (row block, column block, k slice, line) in that nesting.
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wsel   <= 1'b0;
            f_bi   <= '0;
            f_bj   <= '0;
            f_kb   <= '0;
            f_r    <= '0;
            pend   <= '0;
        end else if (go) begin
            active <= 1'b1;
            wsel   <= 1'b0;
            f_bi   <= '0;
            f_bj   <= '0;
            f_kb   <= '0;
            f_r    <= '0;
            pend   <= '0;
        end else begin
            pend <= '{vld: issue, bank: wsel, row: f_r};
            if (issue) begin
                if (f_r == R_LAST) begin
                    f_r  <= '0;
                    wsel <= ~wsel;
                    if (f_kb == B_LAST) begin
                        f_kb <= '0;
                        if (f_bj == B_LAST) begin
                            f_bj <= '0;
                            if (f_bi == B_LAST) active <= 1'b0;
                            else                f_bi   <= f_bi + 1'b1;
                        end else begin
                            f_bj <= f_bj + 1'b1;
                        end
                    end else begin
                        f_kb <= f_kb + 1'b1;
                    end
                end else begin
                    f_r <= f_r + 1'b1;
                end
            end
        end
    end

    // Bank occupancy: set when its last line lands, cleared when consumed.
    always_ff @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (rst || go)
                full[b] <= 1'b0;
            else if (pend.vld && (pend.bank == 1'(b)) && (pend.row == R_LAST))
                full[b] <= 1'b1;
            else if (release_bank && (rd_sel == 1'(b)))
                full[b] <= 1'b0;
        end
    end

    // Staging registers, written one line per cycle.
    always_ff @(posedge clk) begin
        if (pend.vld) begin
            for (int w = 0; w < SUB; w++) begin
                a_bank[pend.bank][pend.row][w] <= opa_rd_data[w*DW +: DW];
                b_bank[pend.bank][pend.row][w] <= opb_rd_data[w*DW +: DW];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SUB; i++) begin
            a_col[i*DW +: DW] = a_bank[rd_sel][i][k_idx];
            b_col[i*DW +: DW] = b_bank[rd_sel][i][k_idx];
        end
    end

    // R2: a landing line never targets a bank still held for the MAC grid.
    p_fill_free_bank_r2: assert property (@(posedge clk) disable iff (rst)
        pend.vld |-> !full[pend.bank]);

endmodule

// File: rtl/tmm_mac.sv
module tmm_mac #(
    parameter int SUB = 16,
    parameter int DW  = 32
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic                  first,
    input  logic [SUB*DW-1:0]     a_col,
    input  logic [SUB*DW-1:0]     b_col,
    output logic [SUB*SUB*DW-1:0] acc_flat
);

    for (genvar i = 0; i < SUB; i++) begin : g_row
        for (genvar j = 0; j < SUB; j++) begin : g_col
            logic [DW-1:0] acc_q;
            logic [DW-1:0] prod;

            // Truncated product: low DW bits are sign-agnostic.
            assign prod = a_col[i*DW +: DW] * b_col[j*DW +: DW];

            always_ff @(posedge clk) begin
                if (en) acc_q <= (first ? '0 : acc_q) + prod;
            end

            assign acc_flat[(i*SUB + j)*DW +: DW] = acc_q;
        end
    end

endmodule

// File: rtl/tmm_tile_engine.sv
module tmm_tile_engine import tmm_pkg::*; #(
    parameter int TILE = 64,
    parameter int SUB  = 16,
    parameter int DW   = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic                               accumulate,
    output logic                               done,
    output logic                               opa_rd_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]  opa_rd_addr,
    input  logic [SUB*DW-1:0]                  opa_rd_data,
    output logic                               opb_rd_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]  opb_rd_addr,
    input  logic [SUB*DW-1:0]                  opb_rd_data,
    output logic                               res_rd_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]  res_rd_addr,
    input  logic [SUB*DW-1:0]                  res_rd_data,
    output logic                               res_wr_en,
    output logic [idx_w(TILE*(TILE/SUB))-1:0]  res_wr_addr,
    output logic [SUB*DW-1:0]                  res_wr_data
);

    localparam int NB = TILE / SUB;
    localparam int BW = idx_w(NB);
    localparam int RW = idx_w(SUB);
    localparam int CW = idx_w(SUB + 1);
    localparam int AW = idx_w(TILE * NB);
    localparam logic [RW-1:0] K_LAST  = RW'(SUB - 1);
    localparam logic [BW-1:0] B_LAST  = BW'(NB - 1);
    localparam logic [CW-1:0] WB_LAST = CW'(SUB);

    cstate_e          state;
    logic [BW-1:0]    c_bi, c_bj, c_kb;
    logic [RW-1:0]    c_k;
    logic [CW-1:0]    wb_cnt;
    logic             rsel;
    logic             acc_mode;
    logic             go;
    logic             mac_en;
    logic             mac_first;
    logic             bank_release;
    logic [1:0]       bank_full;
    logic [SUB*DW-1:0]     a_col, b_col;
    logic [SUB*SUB*DW-1:0] acc_flat;

    assign go           = (state == CS_IDLE) && start;
    assign mac_en       = (state == CS_MAC) && bank_full[rsel];
    assign mac_first    = (c_kb == '0) && (c_k == '0);
    assign bank_release = mac_en && (c_k == K_LAST);

    tmm_fetch #(.TILE(TILE), .SUB(SUB), .DW(DW)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .rd_sel       (rsel),
        .k_idx        (c_k),
        .release_bank (bank_release),
        .opa_rd_en    (opa_rd_en),
        .opa_rd_addr  (opa_rd_addr),
        .opa_rd_data  (opa_rd_data),
        .opb_rd_en    (opb_rd_en),
        .opb_rd_addr  (opb_rd_addr),
        .opb_rd_data  (opb_rd_data),
        .bank_full    (bank_full),
        .a_col        (a_col),
        .b_col        (b_col)
    );

    tmm_mac #(.SUB(SUB), .DW(DW)) u_mac (
        .clk      (clk),
        .en       (mac_en),
        .first    (mac_first),
        .a_col    (a_col),
        .b_col    (b_col),
        .acc_flat (acc_flat)
    );

    // Write-back: read row t at count t, write row t at count t+1.
    always_comb begin
        res_rd_en   = (state == CS_WB) && (wb_cnt < WB_LAST);
        res_rd_addr = AW'(line_of(32'(c_bi) * SUB + 32'(wb_cnt), 32'(c_bj), NB));
        res_wr_en   = (state == CS_WB) && (wb_cnt != '0);
        res_wr_addr = AW'(line_of(32'(c_bi) * SUB + 32'(wb_cnt) - 1, 32'(c_bj), NB));
        res_wr_data = '0;
        if (res_wr_en) begin
            for (int c = 0; c < SUB; c++) begin
                res_wr_data[c*DW +: DW] =
                    acc_flat[((32'(wb_cnt) - 1) * SUB + c) * DW +: DW] +
                    (acc_mode ? res_rd_data[c*DW +: DW] : '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CS_IDLE;
            c_bi     <= '0;
            c_bj     <= '0;
            c_kb     <= '0;
            c_k      <= '0;
            wb_cnt   <= '0;
            rsel     <= 1'b0;
            acc_mode <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                CS_IDLE: begin
                    if (start) begin
                        state    <= CS_MAC;
                        c_bi     <= '0;
                        c_bj     <= '0;
                        c_kb     <= '0;
                        c_k      <= '0;
                        rsel     <= 1'b0;
                        acc_mode <= accumulate;
                    end
                end
                CS_MAC: begin
                    if (mac_en) begin
                        if (c_k == K_LAST) begin
                            c_k  <= '0;
                            rsel <= ~rsel;
                            if (c_kb == B_LAST) begin
                                c_kb   <= '0;
                                wb_cnt <= '0;
                                state  <= CS_WB;
                            end else begin
                                c_kb <= c_kb + 1'b1;
                            end
                        end else begin
                            c_k <= c_k + 1'b1;
                        end
                    end
                end
                CS_WB: begin
                    if (wb_cnt == WB_LAST) begin
                        if (c_bj == B_LAST) begin
                            c_bj <= '0;
                            if (c_bi == B_LAST) begin
                                state <= CS_IDLE;
                                done  <= 1'b1;
                            end else begin
                                c_bi  <= c_bi + 1'b1;
                                state <= CS_MAC;
                            end
                        end else begin
                            c_bj  <= c_bj + 1'b1;
                            state <= CS_MAC;
                        end
                    end else begin
                        wb_cnt <= wb_cnt + 1'b1;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    // R6: completion is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion directly follows a result write.
    p_done_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(res_wr_en));

    // R5: back-to-back writes step down one row of the same sub-block.
    p_row_stride_r5: assert property (@(posedge clk) disable iff (rst)
        (res_wr_en && $past(res_wr_en)) |-> (res_wr_addr == $past(res_wr_addr) + AW'(NB)));

endmodule

// File: tb/tmm_tile_engine_tb_top.sv
module tmm_tile_engine_tb_top;

    localparam int TILE  = 8;
    localparam int SUB   = 4;
    localparam int DW    = 32;
    localparam int NB    = TILE / SUB;
    localparam int LINES = TILE * NB;
    localparam int AW    = 4;
    localparam int LW    = SUB * DW;
    localparam int RUN_BOUND = NB*NB*NB*(SUB+1) + NB*NB*(SUB+1) + 2*SUB + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic accumulate = 1'b0;
    logic done;
    logic opa_rd_en, opb_rd_en, res_rd_en, res_wr_en;
    logic [AW-1:0] opa_rd_addr, opb_rd_addr, res_rd_addr, res_wr_addr;
    logic [LW-1:0] opa_rd_data, opb_rd_data, res_rd_data, res_wr_data;

    always #10 clk = ~clk;

    tmm_tile_engine #(.TILE(TILE), .SUB(SUB), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .accumulate(accumulate), .done(done),
        .opa_rd_en(opa_rd_en), .opa_rd_addr(opa_rd_addr), .opa_rd_data(opa_rd_data),
        .opb_rd_en(opb_rd_en), .opb_rd_addr(opb_rd_addr), .opb_rd_data(opb_rd_data),
        .res_rd_en(res_rd_en), .res_rd_addr(res_rd_addr), .res_rd_data(res_rd_data),
        .res_wr_en(res_wr_en), .res_wr_addr(res_wr_addr), .res_wr_data(res_wr_data)
    );

    logic [LW-1:0] a_mem [LINES];
    logic [LW-1:0] b_mem [LINES];
    logic [LW-1:0] c_mem [LINES];
    logic [31:0] ma [TILE][TILE];
    logic [31:0] mb [TILE][TILE];
    logic [31:0] exp_c [TILE][TILE];

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Scratchpad models: one-cycle read latency.
    always @(posedge clk) begin
        if (opa_rd_en) opa_rd_data <= a_mem[opa_rd_addr];
        if (opb_rd_en) opb_rd_data <= b_mem[opb_rd_addr];
        if (res_rd_en) res_rd_data <= c_mem[res_rd_addr];
        if (res_wr_en) c_mem[res_wr_addr] <= res_wr_data;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] exp_line(input int addr);
        logic [LW-1:0] l;
        for (int w = 0; w < SUB; w++)
            l[w*DW +: DW] = exp_c[addr / NB][(addr % NB) * SUB + w];
        return l;
    endfunction

    // Cycle-by-cycle reference: predicted write sequence.
    int    exp_q[$];
    string cur_req = "R2";
    bit    running = 1'b0;
    int    run_cycles = 0;
    int    done_at = 0;
    int    done_seen = 0;
    bit    prev_wr = 1'b0;
    int    line_wr [LINES];

    always @(negedge clk) begin
        if (running) run_cycles++;
        if (res_wr_en) begin
            if (int'(res_wr_addr) < LINES) line_wr[res_wr_addr]++;
            if (done_seen != 0) check(1'b0, "R6 write after done", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", longint'(res_wr_addr), -1);
            end else begin
                int ea;
                ea = exp_q.pop_front();
                check(int'(res_wr_addr) == ea, "R5 write order", longint'(res_wr_addr), ea);
                check(res_wr_data == exp_line(ea), cur_req,
                      longint'(res_wr_data[63:0]), longint'(exp_line(ea) >> 0) & 64'hFFFF_FFFF_FFFF_FFFF);
            end
        end
        if (done) begin
            check(prev_wr, "R6 done not right after last write", 0, 1);
            if (done_seen == 0) done_at = run_cycles;
            done_seen++;
        end
        prev_wr = res_wr_en;
    end

    function automatic logic [31:0] lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // pattern 0 identity B, 1 small mixed signs, 2 near limits, 3 pseudo-random
    task automatic load(input int pat);
        for (int r = 0; r < TILE; r++) begin
            for (int c = 0; c < TILE; c++) begin
                case (pat)
                    0: begin ma[r][c] = 32'(r*TILE + c + 1); mb[r][c] = (r == c) ? 32'd1 : 32'd0; end
                    1: begin ma[r][c] = 32'(r*3 - c*5); mb[r][c] = 32'(r + 2*c - 7); end
                    2: begin ma[r][c] = 32'h7FFF_FFFF - 32'(r*c); mb[r][c] = 32'h8000_0001 + 32'(r + c); end
                    default: begin ma[r][c] = lcg(); mb[r][c] = lcg(); end
                endcase
            end
        end
        for (int r = 0; r < TILE; r++)
            for (int q = 0; q < NB; q++)
                for (int w = 0; w < SUB; w++) begin
                    a_mem[r*NB + q][w*DW +: DW] = ma[r][q*SUB + w];
                    b_mem[r*NB + q][w*DW +: DW] = mb[q*SUB + w][r];
                end
    endtask

    // poke: 0 none, 1 extra start mid-run, 2 flip accumulate mid-run
    task automatic run(input bit acc, input int poke, input string req);
        int bad;
        logic [31:0] s;
        logic [31:0] got;
        for (int r = 0; r < TILE; r++)
            for (int c = 0; c < TILE; c++) begin
                s = acc ? c_mem[r*NB + c/SUB][(c%SUB)*DW +: DW] : 32'd0;
                for (int k = 0; k < TILE; k++) s = s + ma[r][k] * mb[k][c];
                exp_c[r][c] = s;
            end
        exp_q.delete();
        for (int bi = 0; bi < NB; bi++)
            for (int bj = 0; bj < NB; bj++)
                for (int r = 0; r < SUB; r++)
                    exp_q.push_back((bi*SUB + r)*NB + bj);
        for (int l = 0; l < LINES; l++) line_wr[l] = 0;
        cur_req = req;
        done_seen = 0;
        done_at = 0;
        @(negedge clk); #1;
        start = 1'b1;
        accumulate = acc;
        run_cycles = 0;
        running = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        for (int t = 0; t < 600; t++) begin
            if (t == 10 && poke == 1) start = 1'b1;
            if (t == 11) start = 1'b0;
            if (t == 10 && poke == 2) accumulate = !acc;
            @(negedge clk); #1;
            if (done_seen != 0) break;
        end
        repeat (4) begin @(negedge clk); #1; end
        running = 1'b0;
        accumulate = 1'b0;
        check(done_seen == 1, {req, " R6 single done"}, done_seen, 1);
        check(done_at <= RUN_BOUND, "R9 latency", done_at, RUN_BOUND);
        check(exp_q.size() == 0, "R5 missing writes", exp_q.size(), 0);
        bad = 0;
        for (int l = 0; l < LINES; l++) if (line_wr[l] != 1) bad++;
        check(bad == 0, "R5 each line once", bad, 0);
        bad = 0;
        for (int r = 0; r < TILE; r++)
            for (int c = 0; c < TILE; c++) begin
                got = c_mem[r*NB + c/SUB][(c%SUB)*DW +: DW];
                if (got != exp_c[r][c]) begin
                    if (bad == 0) check(1'b0, {req, " tile"}, got, exp_c[r][c]);
                    bad++;
                end
            end
        if (bad == 0) check(1'b1, {req, " tile"}, 0, 0);
    endtask

    initial begin
        for (int l = 0; l < LINES; l++) c_mem[l] = {SUB{32'hDEAD_BEEF}};
        repeat (5) @(negedge clk);
        // R1: quiet during reset
        check(!done && !opa_rd_en && !opb_rd_en && !res_rd_en && !res_wr_en, "R1 in reset",
              {done, opa_rd_en, opb_rd_en, res_rd_en, res_wr_en}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !opa_rd_en && !opb_rd_en && !res_rd_en && !res_wr_en, "R1 idle",
              {done, opa_rd_en, opb_rd_en, res_rd_en, res_wr_en}, 0);

        load(0); run(1'b0, 0, "R2 identity");
        load(1); run(1'b0, 0, "R2 mixed");
        load(3); run(1'b1, 0, "R3 accumulate");
        load(2); run(1'b0, 0, "R4 wrap");
        run(1'b1, 0, "R4 wrap accumulate");
        load(3); run(1'b0, 1, "R7 start while busy");
        load(1); run(1'b0, 2, "R8 flip to add");
        run(1'b1, 2, "R8 flip to overwrite");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule